// File: doc/BRIEF.md
# Compact-ISA Integer ALU Stage

This block executes the register-to-register arithmetic and logic group of a 24-bit instruction format. It holds a sixteen-entry, 32-bit register file. On each clock edge with `instr_valid` high it decodes the instruction, reads two source registers combinationally, computes the result, and writes it to the destination register on that same edge. One cycle later it raises `done`, and it raises `invalid` as well if the instruction was not one it executes. An instruction that is not executed leaves every register untouched.

Neighbouring stages reach the same register file through two side ports. One is a second write port that carries their writeback. The other is a third read port that any consumer can use. The bench uses these two ports to set up operands and to observe results.

Top module: `cisa_alu_stage`

## Requirements
- R1: `instr` carries six 4-bit fields: bits [3:0] major opcode, [7:4] source t, [11:8] source s, [15:12] destination r, [19:16] minor opcode, [23:20] function code. The group executes only when the major and minor opcodes are both 0.
- R2: Function codes 1, 2 and 3 write s AND t, s OR t and s XOR t to r. Sources are read before the write, so r may equal s or t.
- R3: Function code 6 with s field 0 writes the two's-complement negation of register t to r. With s field 1 it writes the absolute value of register t, and 0x80000000 maps to itself.
- R4: Function codes 8 to 11 write (s << (code-8)) + t, modulo 2^32.
- R5: Function codes 12 to 15 write (s << (code-12)) - t, modulo 2^32.
- R6: The following leave all registers unchanged: function codes 0, 4, 5 and 7, code 6 with s field above 1, and any non-zero major or minor opcode. For each of these, `invalid` is 1 together with `done`.
- R7: `done` is 1 exactly in the cycle after a cycle with `instr_valid` high. `invalid` is 0 for every executed instruction and is never 1 without `done`.
- R8: A synchronous active-high reset clears all sixteen registers and `done`/`invalid`.
- R9: `ext_we` writes `ext_data` to register `ext_idx` on the clock edge. If the ALU writes the same register on the same edge, the ALU value is kept. A write to a different register on that edge also lands.
- R10: `peek_data` shows register `peek_idx` combinationally. A value written on an edge is visible there right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 24 | Instruction word |
| ext_we | input | 1 | Writeback enable from other stages |
| ext_idx | input | 4 | Writeback register index |
| ext_data | input | 32 | Writeback value |
| peek_idx | input | 4 | Third read port index |
| peek_data | output | 32 | Third read port data |
| done | output | 1 | Instruction retired last cycle |
| invalid | output | 1 | Retired instruction was not executed |

## Verification
On every cycle, the embedded properties check the `done`/`invalid` handshake timing, that the registers are zero after reset, that an ALU write lands at its index on the next cycle, and that the absolute value is non-negative except at the wrap point. Whether each result value is arithmetically correct is checked only by the bench, which compares the register file against its own model. The bench alone also shows that unexecuted encodings leave registers untouched, that r may alias s or t, and that the ALU write wins over a side write to the same register on the same edge.

// File: rtl/cisa_alu_pkg.sv
package cisa_alu_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 16;
    localparam int RIDX   = $clog2(NREG);
    localparam int INSN_W = 24;

    typedef enum logic [2:0] {
        OP_AND, OP_OR, OP_XOR, OP_NEG, OP_ABS, OP_ADDSH, OP_SUBSH, OP_NONE
    } alu_op_e;

    // Packed MSB-first: function code in bits [23:20] down to major opcode [3:0]
    typedef struct packed {
        logic [3:0] fn;
        logic [3:0] minor;
        logic [3:0] rd;
        logic [3:0] rs;
        logic [3:0] rt;
        logic [3:0] major;
    } insn_fields_t;

    typedef struct packed {
        alu_op_e         op;
        logic [1:0]      shamt;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic            legal;
    } dec_t;

    function automatic dec_t decode(insn_fields_t f);
        dec_t d;
        d.op    = OP_NONE;
        d.shamt = f.fn[1:0];
        d.rd    = f.rd;
        d.rs    = f.rs;
        d.rt    = f.rt;
        if (f.major == 4'd0 && f.minor == 4'd0) begin
            unique case (f.fn)
                4'd1:  d.op = OP_AND;
                4'd2:  d.op = OP_OR;
                4'd3:  d.op = OP_XOR;
                4'd6:  begin
                           if (f.rs == 4'd0)      d.op = OP_NEG;
                           else if (f.rs == 4'd1) d.op = OP_ABS;
                       end
                4'd8, 4'd9, 4'd10, 4'd11:    d.op = OP_ADDSH;
                4'd12, 4'd13, 4'd14, 4'd15: d.op = OP_SUBSH;
                default: d.op = OP_NONE;
            endcase
        end
        d.legal = (d.op != OP_NONE);
        return d;
    endfunction

endpackage

// File: rtl/cisa_regfile.sv
module cisa_regfile #(
    parameter int XLEN = cisa_alu_pkg::XLEN,
    parameter int NREG = cisa_alu_pkg::NREG,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RIDX-1:0] ra_idx,
    output logic [XLEN-1:0] ra_data,
    input  logic [RIDX-1:0] rb_idx,
    output logic [XLEN-1:0] rb_data,
    input  logic [RIDX-1:0] rc_idx,
    output logic [XLEN-1:0] rc_data,
    input  logic            wa_en,
    input  logic [RIDX-1:0] wa_idx,
    input  logic [XLEN-1:0] wa_data,
    input  logic            wb_en,
    input  logic [RIDX-1:0] wb_idx,
    input  logic [XLEN-1:0] wb_data
);
    logic [XLEN-1:0] regs [NREG];

    // Port A (ALU) has priority over port B (side writeback)
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                regs[i] <= '0;
            else if (wa_en && wa_idx == RIDX'(i))
                regs[i] <= wa_data;
            else if (wb_en && wb_idx == RIDX'(i))
                regs[i] <= wb_data;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
    assign rc_data = regs[rc_idx];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ra_data == '0 && rb_data == '0 && rc_data == '0)); // R8

    AST_ALU_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wa_en |=> regs[$past(wa_idx)] == $past(wa_data)); // R9

endmodule

// File: rtl/cisa_exec.sv
module cisa_exec #(
    parameter int XLEN = cisa_alu_pkg::XLEN
) (
    input  logic                   clk,
    input  logic                   rst,
    input  cisa_alu_pkg::alu_op_e  op,
    input  logic [1:0]             shamt,
    input  logic [XLEN-1:0]        s_val,
    input  logic [XLEN-1:0]        t_val,
    output logic [XLEN-1:0]        result
);
    import cisa_alu_pkg::*;

    logic [XLEN-1:0] s_shifted;
    logic [XLEN-1:0] t_neg;

    assign s_shifted = s_val << shamt;
    assign t_neg     = '0 - t_val;

    always_comb begin
        unique case (op)
            OP_AND:   result = s_val & t_val;
            OP_OR:    result = s_val | t_val;
            OP_XOR:   result = s_val ^ t_val;
            OP_NEG:   result = t_neg;
            OP_ABS:   result = t_val[XLEN-1] ? t_neg : t_val;
            OP_ADDSH: result = s_shifted + t_val;
            OP_SUBSH: result = s_shifted - t_val;
            default:  result = '0;
        endcase
    end

    AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ABS && t_val != {1'b1, {(XLEN-1){1'b0}}}) |-> !result[XLEN-1]); // R3

endmodule

// File: rtl/cisa_alu_stage.sv
module cisa_alu_stage #(
    parameter int XLEN = cisa_alu_pkg::XLEN,
    localparam int RIDX = cisa_alu_pkg::RIDX,
    localparam int IW   = cisa_alu_pkg::INSN_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [IW-1:0]   instr,
    input  logic            ext_we,
    input  logic [RIDX-1:0] ext_idx,
    input  logic [XLEN-1:0] ext_data,
    input  logic [RIDX-1:0] peek_idx,
    output logic [XLEN-1:0] peek_data,
    output logic            done,
    output logic            invalid
);
    import cisa_alu_pkg::*;

    dec_t            dec;
    logic [XLEN-1:0] s_val, t_val, alu_res;
    logic            alu_we;

    assign dec    = decode(insn_fields_t'(instr));
    assign alu_we = instr_valid && dec.legal;

    cisa_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (dec.rs),
        .ra_data (s_val),
        .rb_idx  (dec.rt),
        .rb_data (t_val),
        .rc_idx  (peek_idx),
        .rc_data (peek_data),
        .wa_en   (alu_we),
        .wa_idx  (dec.rd),
        .wa_data (alu_res),
        .wb_en   (ext_we),
        .wb_idx  (ext_idx),
        .wb_data (ext_data)
    );

    cisa_exec #(.XLEN(XLEN)) u_exec (
        .clk    (clk),
        .rst    (rst),
        .op     (dec.op),
        .shamt  (dec.shamt),
        .s_val  (s_val),
        .t_val  (t_val),
        .result (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            invalid <= 1'b0;
        end else begin
            done    <= instr_valid;
            invalid <= instr_valid && !dec.legal;
        end
    end

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> done); // R7

    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(instr_valid)); // R7

    AST_INVALID_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        invalid |-> done); // R7

endmodule

// File: tb/cisa_alu_stage_bench.sv
module cisa_alu_stage_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [23:0] instr = '0;
    logic        ext_we = 1'b0;
    logic [3:0]  ext_idx = '0;
    logic [31:0] ext_data = '0;
    logic [3:0]  peek_idx = '0;
    logic [31:0] peek_data;
    logic        done, invalid;

    int nchk = 0;
    int nfail = 0;
    bit summary_done = 0;
    logic [31:0] model [16];

    always #10 clk = ~clk;

    cisa_alu_stage u_cisa_alu_stage (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .ext_we(ext_we), .ext_idx(ext_idx), .ext_data(ext_data),
        .peek_idx(peek_idx), .peek_data(peek_data),
        .done(done), .invalid(invalid)
    );

    function automatic logic [23:0] mk(int fn, int mn, int r, int s, int t, int mj);
        return {fn[3:0], mn[3:0], r[3:0], s[3:0], t[3:0], mj[3:0]};
    endfunction

    // Returns {executed, value}
    function automatic logic [32:0] ref_op(logic [23:0] ins, logic [31:0] a, logic [31:0] b);
        int fn = int'(ins[23:20]);
        int sf = int'(ins[11:8]);
        if (ins[3:0] != 0 || ins[19:16] != 0) return {1'b0, 32'h0};
        if (fn == 1) return {1'b1, a & b};
        if (fn == 2) return {1'b1, a | b};
        if (fn == 3) return {1'b1, a ^ b};
        if (fn == 6 && sf == 0) return {1'b1, 32'(-b)};
        if (fn == 6 && sf == 1) return {1'b1, ($signed(b) < 0) ? 32'(-b) : b};
        if (fn >= 8 && fn <= 11) return {1'b1, 32'(a * (32'd1 << (fn - 8)) + b)};
        if (fn >= 12) return {1'b1, 32'(a * (32'd1 << (fn - 12)) - b)};
        return {1'b0, 32'h0};
    endfunction

    function automatic string tag_of(logic [23:0] ins);
        int fn = int'(ins[23:20]);
        if (ins[3:0] != 0 || ins[19:16] != 0) return "R1/R6";
        if (fn >= 1 && fn <= 3) return "R2";
        if (fn == 6 && ins[11:8] <= 1) return "R3";
        if (fn >= 8 && fn <= 11) return "R4";
        if (fn >= 12) return "R5";
        return "R6";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(int idx, logic [31:0] val);
        @(negedge clk);
        ext_we = 1'b1; ext_idx = idx[3:0]; ext_data = val;
        @(negedge clk);
        ext_we = 1'b0;
        model[idx] = val;
        peek_idx = idx[3:0];
        #1 chk("R9 load", peek_data, val);
    endtask

    // Issues one instruction, optionally with a side write on the same edge
    task automatic issue(logic [23:0] ins, bit side, int sidx, logic [31:0] sval);
        logic [32:0] e;
        int rd = int'(ins[15:12]);
        e = ref_op(ins, model[ins[11:8]], model[ins[7:4]]);
        @(negedge clk);
        instr_valid = 1'b1; instr = ins;
        ext_we = side; ext_idx = sidx[3:0]; ext_data = sval;
        @(negedge clk);
        instr_valid = 1'b0; ext_we = 1'b0;
        if (side) model[sidx] = sval;
        if (e[32]) model[rd] = e[31:0];
        chk("R7 done", {31'b0, done}, 32'd1);
        chk({tag_of(ins), " invalid"}, {31'b0, invalid}, {31'b0, !e[32]});
        peek_idx = rd[3:0];
        #1 chk({tag_of(ins), " R10 result"}, peek_data, model[rd]);
        if (side) begin
            peek_idx = sidx[3:0];
            #1 chk("R9 side", peek_data, model[sidx]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 done", {31'b0, done}, 32'd0);
        chk("R8 invalid", {31'b0, invalid}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            peek_idx = i[3:0];
            #1 chk("R8 reg", peek_data, 32'd0);
        end
        @(negedge clk);
        chk("R7 idle", {31'b0, done}, 32'd0);

        load(1, 32'h8000_0000);
        load(2, 32'hFFFF_FFF6);
        load(3, 32'h0000_1234);
        load(4, 32'hF0F0_0F0F);
        // Directed corner cases
        issue(mk(6, 0, 5, 1, 1, 0), 0, 0, 0);          // R3 ABS wrap
        chk("R3 abs wrap", model[5], 32'h8000_0000);
        issue(mk(6, 0, 6, 1, 2, 0), 0, 0, 0);          // R3 ABS -10
        chk("R3 abs", model[6], 32'd10);
        issue(mk(6, 0, 7, 0, 0, 0), 0, 0, 0);          // R3 NEG 0
        issue(mk(6, 0, 7, 0, 3, 0), 0, 0, 0);          // R3 NEG
        issue(mk(6, 0, 8, 2, 3, 0), 0, 0, 0);          // R6 reserved s
        issue(mk(11, 0, 3, 3, 3, 0), 0, 0, 0);         // R4 alias r=s=t
        issue(mk(15, 0, 4, 4, 2, 0), 0, 0, 0);         // R5 shift-sub
        issue(mk(0, 0, 4, 1, 2, 0), 0, 0, 0);          // R6 fn 0
        issue(mk(4, 0, 4, 1, 2, 0), 0, 0, 0);          // R6 fn 4
        issue(mk(8, 0, 4, 1, 2, 5), 0, 0, 0);          // R1 major != 0
        issue(mk(8, 3, 4, 1, 2, 0), 0, 0, 0);          // R1 minor != 0
        issue(mk(2, 0, 9, 1, 4, 0), 1, 9, 32'hDEAD_BEEF); // R9 same reg, ALU wins
        issue(mk(12, 0, 10, 4, 3, 0), 1, 11, 32'h0BAD_F00D); // R9 different reg
        issue(mk(7, 0, 12, 4, 3, 0), 1, 12, 32'h1111_2222);  // R6 with side write

        for (int n = 0; n < 400; n++) begin
            int fn, mj, mn, sf;
            if (($urandom % 6) == 0)
                load(int'($urandom % 16), $urandom);
            fn = int'($urandom % 16);
            mj = (($urandom % 12) == 0) ? int'($urandom % 15) + 1 : 0;
            mn = (($urandom % 12) == 0) ? int'($urandom % 15) + 1 : 0;
            sf = int'($urandom % 16);
            if (fn == 6 && ($urandom % 2) == 0) sf = int'($urandom % 3);
            issue(mk(fn, mn, int'($urandom % 16), sf, int'($urandom % 16), mj), 0, 0, 0);
        end

        @(negedge clk);
        chk("R7 idle end", {31'b0, done}, 32'd0);
        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        end
        $finish;
    end

endmodule